// File: doc/BRIEF.md
# Decimal Floating-Point Adder/Subtractor

This unit adds or subtracts two decimal floating-point numbers over several clock cycles. Each operand has three fields: a sign bit, a two-digit exponent biased by 50, and an eight-digit fraction. Every digit is a 4-bit excess-3 code, so the decimal digit d is stored as d+3. The fraction is held as sign and magnitude, and the point sits to the left of its leading digit.

The caller presents both operands and an add/subtract select, then pulses start for one cycle. The unit first equalises the exponents. It does this by shifting the fraction of the operand with the smaller exponent right by one digit per cycle. Next it forms the sum or difference in one cycle, using ten's complement for unlike effective signs, and returns the result to sign and magnitude. It then normalises the result and pulses done. Digits that fall off the right end at any step are dropped, so the result is truncated.

Top module: `dfp_addsub`

## Requirements
- R1: Operand and result layout. Bit 40 is the sign (1 means negative). Bits 39:36 hold the tens digit of the exponent and bits 35:32 its units digit. The stored exponent equals the true exponent plus 50, covering true values -50 to 49. Bits 31:28 hold the first fraction digit after the point and bits 3:0 the eighth. Every digit is coded as its value plus 3.
- R2: While the exponents differ, the operand with the smaller exponent has its fraction shifted right by one digit and its exponent raised by one, once per cycle. Digits shifted out are discarded.
- R3: When the effective signs are equal, the result magnitude is the sum of the aligned fractions and the result carries that common sign.
- R4: When the effective signs differ, the result magnitude is the difference of the aligned fractions, and the result takes the sign of the operand with the larger aligned magnitude.
- R5: When sub is high at start, the sign of op_b is inverted before any sign-dependent handling.
- R6: A carry out of the leading fraction digit shifts the fraction right one digit, inserts a leading 1, and raises the exponent by one. The lowest digit is dropped.
- R7: A nonzero result is normalised: its leading fraction digit is not zero. Each leading zero digit is removed by a left shift with an exponent decrement.
- R8: An exact zero result is coded with sign 0, stored exponent 00 and all fraction digits 0.
- R9: If the carry shift of R6 would take the true exponent above 49, overflow is raised. In that case the exponent stays at 49 and the shifted fraction is returned.
- R10: If normalisation would take the true exponent below -50, the result is replaced by the zero of R8 and underflow is raised. Overflow and underflow are never both high.
- R11: A start while idle raises busy on the next cycle. done is a one-cycle pulse, and busy is low while done is high. result, overflow and underflow are valid from done until the next accepted start.
- R12: A start pulse seen while busy is ignored, and the operation in progress finishes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request, taken only when idle |
| sub | input | 1 | 1 selects op_a minus op_b, 0 selects op_a plus op_b |
| op_a | input | 41 | First operand (R1 layout) |
| op_b | input | 41 | Second operand (R1 layout) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 41 | Result (R1 layout) |
| overflow | output | 1 | Exponent overflow on the last result |
| underflow | output | 1 | Exponent underflow flush on the last result |

## Verification
The bench aims at the points where decimal arithmetic is easy to get wrong. A fraction carry is one case: a design without the right shift would return a result off by a factor of ten with a wrong leading digit. Unlike signs with a negative outcome are another: a design that skips the recomplement step returns the nine's/ten's complement digits, such as 7 in place of 3. The bench also covers deep cancellation that needs six left shifts, and alignment that truncates the digits shifted out. At the exponent boundaries it checks two failures: a 99 that wraps to 00 where overflow should be raised, and a result left unnormalised where underflow should flush it to zero. It confirms that an exact zero comes out positive with the minimum exponent, and that a start during busy does not corrupt the operation under way.

// File: rtl/dfp_addsub.sv
module dfp_addsub #(
  parameter int ND = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sub,
  input  logic [4*ND+8:0]   op_a,
  input  logic [4*ND+8:0]   op_b,
  output logic              busy,
  output logic              done,
  output logic [4*ND+8:0]   result,
  output logic              overflow,
  output logic              underflow
);
  localparam int FW = 4*ND;
  localparam int OW = FW + 9;
  localparam logic [6:0] EMAX = 7'd99;

  typedef enum logic [1:0] {IDLE, ALIGN, ADD, NORM} st_t;
  st_t st;

  logic [FW-1:0] fa, fb;
  logic [6:0]    ea, eb;
  logic          sa, sb, ovf, unf, done_q;

  function automatic logic [FW-1:0] xs3(input logic [FW-1:0] x, input logic enc);
    logic [FW-1:0] y;
    for (int i = 0; i < ND; i++)
      y[4*i +: 4] = enc ? x[4*i +: 4] + 4'd3 : x[4*i +: 4] - 4'd3;
    return y;
  endfunction

  function automatic logic [FW-1:0] nines(input logic [FW-1:0] x);
    logic [FW-1:0] y;
    for (int i = 0; i < ND; i++) y[4*i +: 4] = 4'd9 - x[4*i +: 4];
    return y;
  endfunction

  function automatic logic [FW:0] dadd(input logic [FW-1:0] a, input logic [FW-1:0] b, input logic ci);
    logic [FW-1:0] s;
    logic [4:0]    t;
    logic          c;
    c = ci;
    for (int i = 0; i < ND; i++) begin
      t = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'd0, c};
      if (t > 5'd9) begin s[4*i +: 4] = 4'(t - 5'd10); c = 1'b1; end
      else          begin s[4*i +: 4] = t[3:0];        c = 1'b0; end
    end
    return {c, s};
  endfunction

  function automatic logic [FW-1:0] tens(input logic [FW-1:0] x);
    logic [FW:0] r;
    r = dadd(nines(x), '0, 1'b1);
    return r[FW-1:0];
  endfunction

  function automatic logic [6:0] edec(input logic [7:0] x);
    return 7'(x[7:4] - 4'd3) * 7'd10 + 7'(x[3:0] - 4'd3);
  endfunction

  function automatic logic [7:0] eenc(input logic [6:0] v);
    logic [6:0] h, l;
    h = v / 7'd10;
    l = v % 7'd10;
    return {h[3:0] + 4'd3, l[3:0] + 4'd3};
  endfunction

  logic          like;
  logic [FW:0]   sum;
  logic [FW-1:0] recomp;

  assign like   = (sa == sb);
  assign sum    = dadd(fa, like ? fb : nines(fb), !like);
  assign recomp = tens(sum[FW-1:0]);

  assign busy      = (st != IDLE);
  assign done      = done_q;
  assign overflow  = ovf;
  assign underflow = unf;
  assign result    = {sa, eenc(ea), xs3(fa, 1'b1)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE;
      fa <= '0; fb <= '0; ea <= '0; eb <= '0;
      sa <= 1'b0; sb <= 1'b0; ovf <= 1'b0; unf <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        IDLE: if (start) begin
          sa  <= op_a[OW-1];
          sb  <= op_b[OW-1] ^ sub;
          ea  <= edec(op_a[FW+7:FW]);
          eb  <= edec(op_b[FW+7:FW]);
          fa  <= xs3(op_a[FW-1:0], 1'b0);
          fb  <= xs3(op_b[FW-1:0], 1'b0);
          ovf <= 1'b0;
          unf <= 1'b0;
          st  <= ALIGN;
        end
        ALIGN: begin
          if (ea < eb)      begin fa <= fa >> 4; ea <= ea + 7'd1; end
          else if (eb < ea) begin fb <= fb >> 4; eb <= eb + 7'd1; end
          else st <= ADD;
        end
        ADD: begin
          if (like) begin
            if (sum[FW]) begin
              fa <= {4'd1, sum[FW-1:4]};
              if (ea == EMAX) ovf <= 1'b1;
              else            ea  <= ea + 7'd1;
            end else fa <= sum[FW-1:0];
          end else if (sum[FW]) begin
            fa <= sum[FW-1:0];
          end else begin
            fa <= recomp;
            sa <= sb;
          end
          st <= NORM;
        end
        NORM: begin
          if (fa == '0) begin
            sa <= 1'b0; ea <= '0; done_q <= 1'b1; st <= IDLE;
          end else if (fa[FW-1 -: 4] == 4'd0) begin
            if (ea == '0) begin
              fa <= '0; sa <= 1'b0; unf <= 1'b1; done_q <= 1'b1; st <= IDLE;
            end else begin
              fa <= fa << 4; ea <= ea - 7'd1;
            end
          end else begin
            done_q <= 1'b1; st <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  assert_align_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ADD) |-> (ea == eb));
  assert_normalised_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fa != '0) |-> (fa[FW-1 -: 4] != 4'd0));
  assert_zero_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fa == '0) |-> (!sa && ea == '0));
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(overflow && underflow));
  assert_underflow_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && underflow) |-> (fa == '0));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_busy_after_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/dfp_addsub_bench.sv
module dfp_addsub_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, sub = 1'b0;
  logic [40:0] op_a = '0, op_b = '0;
  logic busy, done, overflow, underflow;
  logic [40:0] result;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  dfp_addsub u_dfp_addsub (
    .clk(clk), .rst_n(rst_n), .start(start), .sub(sub), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .result(result), .overflow(overflow), .underflow(underflow)
  );

  function automatic logic [40:0] pk(input logic s, input int te, input int f);
    logic [40:0] r;
    int v, e;
    e = te + 50;
    r[40] = s;
    r[39:36] = 4'(e / 10 + 3);
    r[35:32] = 4'(e % 10 + 3);
    v = f;
    for (int i = 0; i < 8; i++) begin
      r[4*i +: 4] = 4'(v % 10 + 3);
      v = v / 10;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [40:0] act, input logic [40:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic go(input logic [40:0] a, input logic [40:0] b, input logic s,
                    input logic [40:0] er, input logic eo, input logic eu, input string tag);
    bit seen;
    @(negedge clk);
    op_a = a; op_b = b; sub = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " busy R11"}, {40'd0, busy}, 41'd1);
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk({tag, " done seen R11"}, {40'd0, seen}, 41'd1);
    chk({tag, " result"}, result, er);
    chk({tag, " overflow R9"}, {40'd0, overflow}, {40'd0, eo});
    chk({tag, " underflow R10"}, {40'd0, underflow}, {40'd0, eu});
    @(negedge clk);
    chk({tag, " done pulse R11"}, {39'd0, done, busy}, 41'd0);
  endtask

  task automatic t_reset();
    chk("reset busy R11", {40'd0, busy}, 41'd0);
    chk("reset done R11", {40'd0, done}, 41'd0);
    chk("reset result R8", result, pk(1'b0, -50, 0));
  endtask

  task automatic t_encoding();
    go(pk(1'b1, -12, 37100000), pk(1'b0, -50, 0), 1'b0,
       41'b1_0110_1011_0110_1010_0100_0011_0011_0011_0011_0011, 1'b0, 1'b0, "encoding R1");
  endtask

  task automatic t_like();
    go(pk(0, 5, 12345678), pk(0, 5, 11111111), 0, pk(0, 5, 23456789), 0, 0, "like add R3");
    go(pk(1, -3, 21000000), pk(1, -3, 33000000), 0, pk(1, -3, 54000000), 0, 0, "neg like add R3");
  endtask

  task automatic t_carry();
    go(pk(0, 2, 60000000), pk(0, 2, 70000000), 0, pk(0, 3, 13000000), 0, 0, "carry R6");
  endtask

  task automatic t_align();
    go(pk(0, 3, 50000000), pk(0, 1, 50000000), 0, pk(0, 3, 50500000), 0, 0, "align R2");
    go(pk(0, -2, 99999999), pk(0, 0, 12345678), 0, pk(0, 0, 13345677), 0, 0, "align trunc R2");
  endtask

  task automatic t_unlike();
    go(pk(0, 3, 50000000), pk(0, 3, 20000000), 1, pk(0, 3, 30000000), 0, 0, "subtract R5");
    go(pk(0, 3, 20000000), pk(1, 3, 50000000), 0, pk(1, 3, 30000000), 0, 0, "neg diff R4");
    go(pk(0, 0, 30000000), pk(1, 0, 20000000), 1, pk(0, 0, 50000000), 0, 0, "sub neg b R5");
  endtask

  task automatic t_norm();
    go(pk(0, 4, 12345678), pk(0, 4, 12345600), 1, pk(0, -2, 78000000), 0, 0, "cancel R7");
  endtask

  task automatic t_zero();
    go(pk(1, 7, 50000000), pk(1, 7, 50000000), 1, pk(0, -50, 0), 0, 0, "exact zero R8");
  endtask

  task automatic t_overflow();
    go(pk(0, 49, 90000000), pk(0, 49, 90000000), 0, pk(0, 49, 18000000), 1, 0, "overflow R9");
  endtask

  task automatic t_underflow();
    go(pk(0, -50, 15000000), pk(0, -50, 14000000), 1, pk(0, -50, 0), 0, 1, "underflow R10");
  endtask

  task automatic t_busy_start();
    bit seen;
    @(negedge clk);
    op_a = pk(0, 0, 10000000); op_b = pk(0, 0, 10000000); sub = 0; start = 1'b1;
    @(negedge clk);
    op_a = pk(0, 0, 90000000); op_b = pk(0, 0, 90000000); sub = 1;
    @(negedge clk);
    start = 1'b0;
    seen = 0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (done) seen = 1; else @(negedge clk);
    end
    chk("busy start done R12", {40'd0, seen}, 41'd1);
    chk("busy start ignored R12", result, pk(0, 0, 20000000));
    @(negedge clk);
    chk("busy start no rerun R12", {39'd0, done, busy}, 41'd0);
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_encoding();
    t_like();
    t_carry();
    t_align();
    t_unlike();
    t_norm();
    t_zero();
    t_overflow();
    t_underflow();
    t_busy_start();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule